// File: doc/BRIEF.md
# Bus Cycle Run/Step Controller

This block decides when the processor on an 8-bit bus may advance. It drives the bus ready line: while ready is low the processor is frozen part-way through a bus cycle, so every latch that shows the address, data and status lines holds a steady value. The controller can let the machine run freely. It can advance it by hand, one opcode fetch or one bus cycle per press of the step button. It can also step it automatically at a slow, selectable rate.

The run/stop switch and the step button are raw mechanical inputs, so the block synchronizes and debounces both. Each bus cycle is marked by a one-clock start strobe and an opcode-fetch flag that is valid with it. A breakpoint unit outside this block raises a hit line. That line halts the machine at once, and leaving the halted state then requires the run switch to be turned off and on again. In slow-step mode a prescaler counts system clocks and fires a step every `(rate_i + 1) * TICK_DIV` clocks spent stopped. This gives a selectable range such as 1 Hz to 1 kHz when one prescaler unit is one millisecond.

Top module: `bus_step_ctrl`

## Requirements
- R1: After reset the state output reads STOP (2'b01) and ready_o is low. The state encoding is RUN = 2'b00, STOP = 2'b01, STEP = 2'b10.
- R2: In STOP, ready_o stays low and the state does not change while no run, step, slow-step or breakpoint event occurs.
- R3: When the debounced run switch is high and the controller is armed, STOP changes to RUN and ready_o is high. When the debounced run switch goes low, RUN changes to STOP.
- R4: A level on run_sw_i or step_sw_i takes effect only after it has been held for DEB_CYC clocks past the SYNC_STAGES synchronizer. A shorter pulse has no effect.
- R5: With step_any_i = 0, a rising edge of the debounced step input in STOP raises ready_o (state STEP). Ready stays high across strobes with m1_i = 0. It falls in the same clock as the first strobe with m1_i = 1, and the state is STOP after the next edge.
- R6: With step_any_i = 1 (sampled when the step starts), ready_o falls in the clock of the first cyc_start_i strobe of any kind, and the state is STOP after the next edge.
- R7: A step request while in RUN is ignored: the state stays RUN and ready_o stays high.
- R8: A bp_hit_i pulse in RUN or STEP drops ready_o in the same clock, and the state is STOP after the next edge.
- R9: After a breakpoint halt, a run switch that is still high does not resume. The run switch must be debounced low and then high again before RUN is entered.
- R10: With slow_en_i = 1 in STOP, a step starts after exactly (rate_i + 1) * TICK_DIV clocks spent in STOP. The prescaler restarts from zero each time STOP is entered or slow stepping is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_sw_i | input | 1 | Raw run/stop switch, 1 = run |
| step_sw_i | input | 1 | Raw single-step button, 1 = pressed |
| step_any_i | input | 1 | Step kind: 0 = to next opcode fetch, 1 = one bus cycle |
| slow_en_i | input | 1 | Enables automatic stepping while stopped |
| rate_i | input | RATE_W | Slow-step period in prescaler units, minus one |
| bp_hit_i | input | 1 | Breakpoint match from the comparator |
| cyc_start_i | input | 1 | One-clock strobe at the start of each bus cycle |
| m1_i | input | 1 | Opcode-fetch status, valid with cyc_start_i |
| ready_o | output | 1 | Bus ready; low freezes the processor |
| state_o | output | 2 | Controller state: 00 run, 01 stop, 10 step |

## Verification
The ready line is combinational in the breakpoint and strobe inputs. The bench therefore drives those inputs at the falling edge and reads ready_o a nanosecond later in the same clock, and reads state_o one clock later. Switch actions pass through the synchronizer, the debounce counter and the state register, about SYNC_STAGES + DEB_CYC + 1 clocks in all, so the bench waits a fixed margin beyond that before it compares. Slow-step timing is measured as an exact count of low-ready clocks, taken from the clock where enabling or re-entering STOP starts the prescaler.

// File: rtl/bus_step_ctrl.sv
module bus_step_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 50000,
  parameter int TICK_DIV    = 50000,
  parameter int RATE_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_sw_i,
  input  logic              step_sw_i,
  input  logic              step_any_i,
  input  logic              slow_en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              bp_hit_i,
  input  logic              cyc_start_i,
  input  logic              m1_i,
  output logic              ready_o,
  output logic [1:0]        state_o
);

  localparam int DEB_W  = $clog2(DEB_CYC + 1);
  localparam int TICK_W = $clog2(TICK_DIV + 1);
  localparam int TOP    = SYNC_STAGES - 1;

  typedef enum logic [1:0] {ST_RUN = 2'b00, ST_STOP = 2'b01, ST_STEP = 2'b10} st_t;

  st_t                  st;
  logic [TOP:0]         run_sy, step_sy;
  logic [DEB_W-1:0]     run_cnt, step_cnt;
  logic                 run_db, step_db, step_db_q;
  logic                 armed, step_any_q;
  logic [TICK_W-1:0]    sub_cnt;
  logic [RATE_W-1:0]    unit_cnt;

  wire step_req   = step_db & ~step_db_q;
  wire step_match = cyc_start_i & (step_any_q | m1_i);
  wire slow_on    = slow_en_i & (st == ST_STOP);
  wire sub_wrap   = (sub_cnt == TICK_W'(TICK_DIV - 1));
  wire slow_fire  = slow_on & sub_wrap & (unit_cnt == rate_i);
  wire go_step    = step_req | slow_fire;

  assign ready_o = ~bp_hit_i & ((st == ST_RUN) | ((st == ST_STEP) & ~step_match));
  assign state_o = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sy  <= '0;
      step_sy <= '0;
    end else begin
      run_sy  <= {run_sy[TOP-1:0], run_sw_i};
      step_sy <= {step_sy[TOP-1:0], step_sw_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_db  <= 1'b0;
      run_cnt <= '0;
    end else if (run_sy[TOP] == run_db) begin
      run_cnt <= '0;
    end else if (run_cnt == DEB_W'(DEB_CYC - 1)) begin
      run_db  <= run_sy[TOP];
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_db   <= 1'b0;
      step_db_q <= 1'b0;
      step_cnt  <= '0;
    end else begin
      step_db_q <= step_db;
      if (step_sy[TOP] == step_db) begin
        step_cnt <= '0;
      end else if (step_cnt == DEB_W'(DEB_CYC - 1)) begin
        step_db  <= step_sy[TOP];
        step_cnt <= '0;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_cnt  <= '0;
      unit_cnt <= '0;
    end else if (!slow_on) begin
      sub_cnt  <= '0;
      unit_cnt <= '0;
    end else if (sub_wrap) begin
      sub_cnt  <= '0;
      unit_cnt <= (unit_cnt == rate_i) ? '0 : unit_cnt + 1'b1;
    end else begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (bp_hit_i) begin
      armed <= 1'b0;
    end else if (!run_db) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_STOP;
      step_any_q <= 1'b0;
    end else begin
      case (st)
        ST_RUN:  if (bp_hit_i || !run_db) st <= ST_STOP;
        ST_STOP: begin
          if (!bp_hit_i && run_db && armed) begin
            st <= ST_RUN;
          end else if (!bp_hit_i && go_step) begin
            st         <= ST_STEP;
            step_any_q <= step_any_i;
          end
        end
        ST_STEP: if (bp_hit_i || step_match) st <= ST_STOP;
        default: st <= ST_STOP;
      endcase
    end
  end

  a_r8_bp_halts: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit_i |=> st == ST_STOP);

  a_r5_step_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STEP && step_match) |=> st == ST_STOP);

  a_r7_run_ignores_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && step_req) |=> st != ST_STEP);

  a_r9_no_resume_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && !armed) |=> st != ST_RUN);

  a_r10_slow_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_STOP) |=> (sub_cnt == '0 && unit_cnt == '0));

endmodule

// File: tb/bus_step_ctrl_test.sv
`timescale 1ns/100ps
module bus_step_ctrl_test;
  localparam int DEB = 4;
  localparam int TD  = 3;
  localparam int RW  = 4;
  localparam int SETTLE = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_sw = 0, step_sw = 0, step_any = 0, slow_en = 0, bp = 0, cyc = 0, m1 = 0;
  logic [RW-1:0] rate = '0;
  logic ready;
  logic [1:0] state;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [1:0] S_RUN = 2'b00, S_STOP = 2'b01, S_STEP = 2'b10;

  bus_step_ctrl #(.SYNC_STAGES(2), .DEB_CYC(DEB), .TICK_DIV(TD), .RATE_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .run_sw_i(run_sw), .step_sw_i(step_sw),
    .step_any_i(step_any), .slow_en_i(slow_en), .rate_i(rate), .bp_hit_i(bp),
    .cyc_start_i(cyc), .m1_i(m1), .ready_o(ready), .state_o(state));

  always #2 clk = ~clk;

  function automatic logic ends_step(logic any, logic fetch);
    return any | fetch;
  endfunction

  function automatic int slow_period(int r);
    return (r + 1) * TD;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_run(logic v);
    run_sw = v;
    wait_n(SETTLE);
  endtask

  task automatic press_step();
    step_sw = 1'b1;
    wait_n(SETTLE);
    step_sw = 1'b0;
    wait_n(SETTLE);
  endtask

  task automatic strobe(logic fetch, logic any, string tag);
    logic fin;
    fin = ends_step(any, fetch);
    cyc = 1'b1; m1 = fetch;
    #1 chk({tag, " ready in strobe clock"}, ready, !fin);
    @(negedge clk);
    cyc = 1'b0; m1 = 1'b0;
    chk({tag, " state after strobe"}, state, fin ? S_STOP : S_STEP);
  endtask

  task automatic measure_slow(int r);
    int n;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (ready) break;
    end
    chk("R10 slow-step period", n, slow_period(r));
    chk("R10 slow-step state", state, S_STEP);
  endtask

  initial begin
    void'($urandom(32'd2718));
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", state, S_STOP);
    chk("R1 reset ready", ready, 0);
    wait_n(10);
    chk("R2 idle stop state", state, S_STOP);
    chk("R2 idle stop ready", ready, 0);

    step_sw = 1'b1; wait_n(2); step_sw = 1'b0; wait_n(SETTLE);
    chk("R4 short step pulse state", state, S_STOP);
    chk("R4 short step pulse ready", ready, 0);
    run_sw = 1'b1; wait_n(3); run_sw = 1'b0; wait_n(SETTLE);
    chk("R4 short run pulse", state, S_STOP);

    for (int s = 0; s < 8; s++) begin
      logic any;
      any = (s < 2) ? logic'(s) : logic'($urandom % 2);
      step_any = any;
      press_step();
      chk(any ? "R6 step started" : "R5 step started", state, S_STEP);
      chk(any ? "R6 ready released" : "R5 ready released", ready, 1);
      for (int j = 0; j < 16; j++) begin
        logic f;
        wait_n($urandom % 3);
        f = (j == 15) ? 1'b1 : logic'(($urandom % 4) == 0);
        strobe(f, any, any ? "R6" : "R5");
        if (ends_step(any, f)) break;
      end
      chk("R2 frozen after step", ready, 0);
    end

    set_run(1'b1);
    chk("R3 run state", state, S_RUN);
    chk("R3 run ready", ready, 1);
    press_step();
    chk("R7 step ignored in run state", state, S_RUN);
    chk("R7 step ignored in run ready", ready, 1);
    cyc = 1'b1; m1 = 1'b1; @(negedge clk); cyc = 1'b0; m1 = 1'b0;
    chk("R7 strobes leave run", state, S_RUN);
    set_run(1'b0);
    chk("R3 stop state", state, S_STOP);
    chk("R3 stop ready", ready, 0);

    set_run(1'b1);
    bp = 1'b1;
    #1 chk("R8 ready drops with hit", ready, 0);
    @(negedge clk); bp = 1'b0;
    chk("R8 state after hit", state, S_STOP);
    wait_n(SETTLE);
    chk("R9 no resume with switch high", state, S_STOP);
    chk("R9 still frozen", ready, 0);
    step_any = 1'b1;
    press_step();
    chk("R8 step after halt", state, S_STEP);
    bp = 1'b1;
    #1 chk("R8 ready drops in step", ready, 0);
    @(negedge clk); bp = 1'b0;
    chk("R8 step halted", state, S_STOP);
    set_run(1'b0);
    chk("R9 still stopped with switch low", state, S_STOP);
    set_run(1'b1);
    chk("R9 fresh run resumes", state, S_RUN);
    set_run(1'b0);

    for (int t = 0; t < 4; t++) begin
      int r;
      r = (t == 0) ? 0 : int'($urandom % 6);
      rate = RW'(r);
      step_any = 1'b1;
      @(negedge clk);
      slow_en = 1'b1;
      measure_slow(r);
      cyc = 1'b1; @(negedge clk); cyc = 1'b0;
      chk("R10 slow step ended", state, S_STOP);
      measure_slow(r);
      cyc = 1'b1; @(negedge clk); cyc = 1'b0; slow_en = 1'b0;
      wait_n(3 * slow_period(r) + 4);
      chk("R10 disabled slow step", state, S_STOP);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule